// File: doc/BRIEF.md
# Serial Audio Input Deserializer

This block turns a stereo serial audio stream into parallel samples. It takes a bit clock, a word clock that marks the channel, and a data line. It delivers one 32-bit left sample and one 32-bit right sample per frame, together with a one-cycle valid strobe. The block runs directly in the bit-clock domain, and every pin is sampled on the rising edge of that clock.

A format input selects the framing: left-justified, I2S or right-justified. A depth input sets how many trailing bits form the word in right-justified framing. A slot that carries fewer bit clocks than the word needs produces a truncated word, never a shifted one. Samples leave exactly as received, with no dither and no rounding, apart from those truncation rules. A left/right pair is released only when the word-clock edge that closes the right slot is seen.

Top module: `audio_rx_deser`

## Requirements
- R1: With format code 00 (left-justified), the bit sampled on the first rising bit-clock edge at which a new word-clock level is seen is the MSB (bit 31). The following bits fill bits 30 down to 0. Word clock high marks the left channel.
- R2: With format code 01 (I2S), the MSB arrives one bit clock later than in R1, and word clock low marks the left channel.
- R3: With format code 10 (right-justified), the last bit sampled before the word clock changes is the LSB. Depth code 00, 01, 10 and 11 keeps the last 16, 20, 24 and 32 received bits. That word is output with its MSB at bit 31 and zeros below it. Earlier bits of a longer slot are discarded.
- R4: In left-justified and I2S framing, a slot with fewer than 32 bit clocks leaves the missing low bits zero. Bits beyond the 32nd in a longer slot are ignored.
- R5: In right-justified framing, a slot with fewer bit clocks than the depth leaves the missing upper bits of the word zero.
- R6: valid_o is high for exactly one bit-clock cycle. It rises in the cycle after the edge at which the end of a right slot is detected, and only if a left slot was completed just before. left_o and right_o change only together with valid_o.
- R7: Synchronous reset clears valid_o, left_o and right_o. A slot that is already in progress when reset ends produces no output. Capture starts at the first word-clock change observed after reset.
- R8: Format code 11 behaves exactly as left-justified framing, and no dither or rounding is applied to the sample values in any format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all inputs sampled and all state updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Framing: 00 left-justified, 01 I2S, 10 right-justified, 11 as 00 |
| depth | input | 2 | Right-justified word size: 00 16, 01 20, 10 24, 11 32 bits |
| lrck | input | 1 | Word clock marking the channel |
| sdata | input | 1 | Serial data, MSB first |
| left_o | output | 32 | Left sample of the last complete frame |
| right_o | output | 32 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Random sample pairs are sent in every framing, with slot lengths drawn both above and below the word size. Slot lengths above the word size show that extra bits are discarded, with the discarded positions filled with random values so that any leak shows up. Slot lengths below the word size show truncation against misalignment. A slot of a single bit clock tests the boundary handling at its tightest. A stream that starts mid-slot after reset shows that a partial slot or an orphan right slot is never paired. The reserved format code is run against the left-justified expectation.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int IDX_W    = $clog2(SAMPLE_W);
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t l;
        sample_t r;
    } pair_t;

    // Left-align the trailing word of a right-justified slot.
    function automatic sample_t rj_place(sample_t sh, logic [1:0] code);
        case (code)
            2'b00:   return {sh[15:0], 16'b0};
            2'b01:   return {sh[19:0], 12'b0};
            2'b10:   return {sh[23:0], 8'b0};
            default: return sh;
        endcase
    endfunction

endpackage

// File: rtl/ws_tracker.sv
module ws_tracker
    import audio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fmt,
    input  logic       lrck,
    output logic       slot_edge,
    output logic       new_left
);
    logic       lr_q, lr_qq;
    logic [1:0] prime;
    logic       dly;
    logic       cur, prv;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q  <= 1'b0;
            lr_qq <= 1'b0;
            prime <= 2'd0;
        end else begin
            lr_q  <= lrck;
            lr_qq <= lr_q;
            if (prime != 2'd2) prime <= prime + 2'd1;
        end
    end

    // I2S places its slot boundary one bit clock after the word-clock change.
    always_comb begin
        dly       = (fmt_e'(fmt) == FMT_I2S);
        cur       = dly ? lr_q  : lrck;
        prv       = dly ? lr_qq : lr_q;
        slot_edge = (prime == 2'd2) && (cur != prv);
        new_left  = dly ? ~cur : cur;
    end
endmodule

// File: rtl/word_builder.sv
module word_builder
    import audio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fmt,
    input  logic [1:0] depth,
    input  logic       slot_edge,
    input  logic       sdata,
    output sample_t    word
);
    sample_t          acc;
    sample_t          sh;
    logic [CNT_W-1:0] k;
    logic [IDX_W-1:0] idx;

    assign idx = IDX_W'(SAMPLE_W - 1) - k[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            sh  <= '0;
            k   <= '0;
        end else if (slot_edge) begin
            acc <= {sdata, {(SAMPLE_W-1){1'b0}}};
            sh  <= {{(SAMPLE_W-1){1'b0}}, sdata};
            k   <= CNT_W'(1);
        end else begin
            sh <= {sh[SAMPLE_W-2:0], sdata};
            if (k < CNT_W'(SAMPLE_W)) begin
                acc[idx] <= sdata;
                k        <= k + CNT_W'(1);
            end
        end
    end

    // Word of the slot that the current boundary closes.
    always_comb begin
        if (fmt_e'(fmt) == FMT_RJ) word = rj_place(sh, depth);
        else                       word = acc;
    end
endmodule

// File: rtl/pair_stage.sv
module pair_stage
    import audio_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    slot_edge,
    input  logic    new_left,
    input  sample_t word,
    output pair_t   pair,
    output logic    valid
);
    sample_t hold_l;
    logic    have_l;
    logic    open;
    logic    cur_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l   <= '0;
            have_l   <= 1'b0;
            open     <= 1'b0;
            cur_left <= 1'b0;
            pair     <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (slot_edge) begin
                open     <= 1'b1;
                cur_left <= new_left;
                if (open) begin
                    if (cur_left) begin
                        hold_l <= word;
                        have_l <= 1'b1;
                    end else if (have_l) begin
                        pair   <= '{l: hold_l, r: word};
                        valid  <= 1'b1;
                        have_l <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser
    import audio_rx_pkg::*;
(
    input  logic                bclk,
    input  logic                rst,
    input  logic [1:0]          fmt,
    input  logic [1:0]          depth,
    input  logic                lrck,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic    slot_edge;
    logic    new_left;
    sample_t word;
    pair_t   pair;

    ws_tracker i_ws (
        .clk       (bclk),
        .rst       (rst),
        .fmt       (fmt),
        .lrck      (lrck),
        .slot_edge (slot_edge),
        .new_left  (new_left)
    );

    word_builder i_wb (
        .clk       (bclk),
        .rst       (rst),
        .fmt       (fmt),
        .depth     (depth),
        .slot_edge (slot_edge),
        .sdata     (sdata),
        .word      (word)
    );

    pair_stage i_ps (
        .clk       (bclk),
        .rst       (rst),
        .slot_edge (slot_edge),
        .new_left  (new_left),
        .word      (word),
        .pair      (pair),
        .valid     (valid_o)
    );

    assign left_o  = pair.l;
    assign right_o = pair.r;
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk
    import audio_rx_pkg::*;
(
    input logic                bclk,
    input logic                rst,
    input logic [1:0]          fmt,
    input logic [1:0]          depth,
    input logic                lrck,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o
);
    // R6
    valid_single_chk: assert property (@(posedge bclk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6
    hold_outputs_chk: assert property (@(posedge bclk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R7
    reset_clear_chk: assert property (@(posedge bclk)
        rst |=> (!valid_o && left_o == '0 && right_o == '0));

    // R1
    lj_edge_chk: assert property (@(posedge bclk) disable iff (rst)
        (valid_o && fmt != 2'b01) |-> ($past(lrck) != $past(lrck, 2)));

    // R2
    i2s_edge_chk: assert property (@(posedge bclk) disable iff (rst)
        (valid_o && fmt == 2'b01) |-> ($past(lrck, 2) != $past(lrck, 3)));

    // R3
    rj16_low_zero_chk: assert property (@(posedge bclk) disable iff (rst)
        (valid_o && fmt == 2'b10 && depth == 2'b00) |->
        (left_o[15:0] == 16'h0 && right_o[15:0] == 16'h0));
endmodule

bind audio_rx_deser audio_rx_chk i_audio_rx_chk (
    .bclk    (bclk),
    .rst     (rst),
    .fmt     (fmt),
    .depth   (depth),
    .lrck    (lrck),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/test_audio_rx_deser.sv
module test_audio_rx_deser;
    logic        bclk = 1'b0;
    logic        rst  = 1'b1;
    logic [1:0]  fmt  = 2'b00;
    logic [1:0]  depth = 2'b00;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [31:0] left_o, right_o;
    logic        valid_o;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    logic        prev_d = 1'b0;
    logic [31:0] exp_l[$];
    logic [31:0] exp_r[$];
    string       cur_req = "R1";

    always #5 bclk = ~bclk;

    audio_rx_deser i_audio_rx_deser (
        .bclk(bclk), .rst(rst), .fmt(fmt), .depth(depth),
        .lrck(lrck), .sdata(sdata),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int dbits(input logic [1:0] c);
        case (c)
            2'b00: return 16;
            2'b01: return 20;
            2'b10: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] low_mask(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic logic [31:0] expect_word(input logic [1:0] f, input logic [1:0] dc,
                                                input logic [31:0] w, input int n);
        int d, e;
        if (f == 2'b10) begin
            d = dbits(dc);
            e = (n < d) ? n : d;
            return (w & low_mask(e)) << (32 - d);
        end
        if (n >= 32) return w;
        return w & ~low_mask(32 - n);
    endfunction

    // Monitor: compare each released pair with the oldest expected one.
    always @(negedge bclk) begin
        if (!rst && valid_o) begin
            if (exp_l.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7 unexpected pair actual=%h/%h expected=none", left_o, right_o);
            end else begin
                check({cur_req, " left"},  left_o,  exp_l.pop_front());
                check({cur_req, " right"}, right_o, exp_r.pop_front());
            end
        end
    end

    task automatic drive_bit(input logic lr, input logic d);
        @(negedge bclk);
        lrck  = lr;
        sdata = (fmt == 2'b01) ? prev_d : d;
        prev_d = d;
    endtask

    task automatic send_slot(input logic lr, input logic [31:0] w, input int n);
        int d;
        d = dbits(depth);
        for (int i = 0; i < n; i++) begin
            logic b;
            if (fmt == 2'b10) begin
                int p;
                p = n - 1 - i;
                b = (p < d) ? w[p] : 1'($urandom);
            end else begin
                b = (i < 32) ? w[31 - i] : 1'($urandom);
            end
            drive_bit(lr, b);
        end
    endtask

    function automatic logic left_lvl();
        return (fmt == 2'b01) ? 1'b0 : 1'b1;
    endfunction

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int n);
        exp_l.push_back(expect_word(fmt, depth, l, n));
        exp_r.push_back(expect_word(fmt, depth, r, n));
        send_slot(left_lvl(), l, n);
        send_slot(~left_lvl(), r, n);
    endtask

    task automatic start_group(input logic [1:0] f, input logic [1:0] dc, input string req);
        rst = 1'b1;
        @(negedge bclk);
        fmt = f; depth = dc; cur_req = req;
        lrck = ~left_lvl(); sdata = 1'b0; prev_d = 1'b0;
        repeat (2) @(negedge bclk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) drive_bit(~left_lvl(), 1'b0);
    endtask

    task automatic end_group();
        send_slot(left_lvl(), 32'h0, 32);
        repeat (3) @(negedge bclk);
        check({cur_req, " pending pairs"}, exp_l.size(), 0);
        exp_l.delete(); exp_r.delete();
    endtask

    task automatic random_group(input logic [1:0] f, input logic [1:0] dc,
                                input int frames, input int nmin, input int nmax, input string req);
        start_group(f, dc, req);
        for (int i = 0; i < frames; i++)
            send_frame($urandom, $urandom, nmin + int'($urandom % (nmax - nmin + 1)));
        end_group();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge bclk);
        // R7 reset state
        check("R7 valid", {31'b0, valid_o}, 32'd0);
        check("R7 left",  left_o,  32'd0);
        check("R7 right", right_o, 32'd0);

        // R7: stream begins mid-slot at the left level; nothing may pair
        @(negedge bclk); fmt = 2'b00; depth = 2'b00; lrck = 1'b1; cur_req = "R7";
        @(negedge bclk); rst = 1'b0;
        for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b1);
        send_slot(1'b0, 32'hDEAD_BEEF, 32);
        send_frame(32'h8000_0001, 32'h7FFF_FFFE, 32);
        end_group();

        // R1 directed and random, full and long slots
        start_group(2'b00, 2'b00, "R1");
        send_frame(32'h8000_0000, 32'h0000_0001, 32);
        send_frame(32'hFFFF_FFFF, 32'h0000_0000, 32);
        end_group();
        random_group(2'b00, 2'b00, 20, 32, 40, "R1");
        // R4 short slots, including single-bit slots
        random_group(2'b00, 2'b00, 20, 8, 31, "R4");
        start_group(2'b00, 2'b00, "R4");
        send_frame(32'hFFFF_FFFF, 32'h8000_0000, 1);
        send_frame(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
        end_group();
        // R2 I2S
        random_group(2'b01, 2'b00, 20, 32, 40, "R2");
        random_group(2'b01, 2'b00, 15, 4, 31, "R4");
        // R3 right-justified, each depth, long slots
        random_group(2'b10, 2'b00, 12, 16, 40, "R3");
        random_group(2'b10, 2'b01, 12, 20, 40, "R3");
        random_group(2'b10, 2'b10, 12, 24, 40, "R3");
        random_group(2'b10, 2'b11, 12, 32, 40, "R3");
        // R5 right-justified short slots
        random_group(2'b10, 2'b10, 12, 4, 23, "R5");
        random_group(2'b10, 2'b11, 12, 8, 31, "R5");
        // R8 reserved code behaves as left-justified
        random_group(2'b11, 2'b00, 12, 20, 40, "R8");
        // R6 back-to-back frames gave single pulses (checker); total counts checked above

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 10);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule